// File: doc/BRIEF.md
# Vital Product Data Capability with EEPROM Request Engine

This block is one entry of a PCI configuration-space capability list. The entry describes vital product data. It sits behind the host configuration port as two dwords. The first is a header that holds the capability identifier, the next-item pointer, a VPD byte address and a completion flag. The second is a data dword. Software writes the header to start a transfer between the data dword and a serial EEPROM. It then polls the flag until the transfer has finished.

The block sends each transfer to an external EEPROM controller as a level request. The request holds an address, a direction and the write data, and the controller answers with a one-cycle acknowledge. While the controller is still loading its power-up image (`autoload_busy` high), the capability refuses all host accesses. The serial wire protocol itself belongs to the controller and is not part of this block.

Top module: `vpd_cap`

## Requirements
- R1: After reset the flag, the VPD address and the data dword are all zero, and `ee_req` is low.
- R2: The header is at dword index 40 (byte offset A0h) and reads {flag[31], address[30:16], 00h next pointer[15:8], 03h identifier[7:0]}. The data dword is at index 41 (A4h). Any other index reads zero. `cfg_rdata` carries the value in the cycle after `cfg_rd`.
- R3: A header write with lane 3 enabled and bit 31 clear starts a read, provided the block is idle and the address is in range. The write stores the address (bits 30:24, plus bits 23:16 if lane 2 is enabled) and clears the flag. On the next cycle `ee_req` rises with `ee_we`=0. On the acknowledge, `ee_rdata` is loaded into the data dword and the flag is set.
- R4: A header write with bit 31 set starts a write of the current data dword, with `ee_we`=1. The flag reads 1 while the write is pending, and the acknowledge clears it. The data dword keeps its value.
- R5: A header write whose address is 224 or above starts no EEPROM request and leaves the header unchanged.
- R6: While a request is pending, which includes the cycle of its acknowledge, header writes and data writes have no effect.
- R7: While `autoload_busy` is high, writes have no effect and both dwords read as zero.
- R8: `ee_req` stays high, with `ee_addr`, `ee_we` and `ee_wdata` stable, until `ee_ack`. It falls in the cycle after the acknowledge.
- R9: `ee_dev` is always 0.
- R10: A data-dword write updates only the bytes whose lane enable is set. A header write with lane 3 disabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| autoload_busy | input | 1 | EEPROM power-up load still running |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Write byte-lane enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data, one cycle after cfg_rd |
| ee_req | output | 1 | EEPROM transfer request, held until ack |
| ee_we | output | 1 | 1 = write transfer, 0 = read transfer |
| ee_dev | output | 3 | EEPROM device address (always 0) |
| ee_addr | output | 8 | VPD byte address |
| ee_wdata | output | 32 | Dword to be written |
| ee_ack | input | 1 | One-cycle completion from the controller |
| ee_rdata | input | 32 | Dword read, valid with ee_ack |

## Verification
A host configuration write can land in the same cycle as the controller's acknowledge. In that cycle the flag and the data dword receive the completion while the host write is being turned away. The bench waits for the rising edge of the modelled `ee_ack` and drives a new header write, or a data write, into exactly that cycle. It then reads the header and data dword back. The check passes only if they show the completed transfer and no new request follows.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
    localparam int          DATA_W       = 32;
    localparam int          ADDR_FW      = 15;
    localparam logic [7:0]  CAP_ID_VPD   = 8'h03;
    localparam logic [7:0]  CAP_NEXT_END = 8'h00;
    localparam logic [2:0]  EE_DEV_ADDR  = 3'd0;
endpackage

// File: rtl/vpd_cfg_decode.sv
module vpd_cfg_decode #(
    parameter int         CFG_AW   = 6,
    parameter logic [7:0] CAP_BASE = 8'hA0
) (
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              autoload_busy,
    output logic              hdr_wr,
    output logic              dat_wr,
    output logic              hdr_rd,
    output logic              dat_rd
);
    localparam logic [CFG_AW-1:0] HDR_IDX = CFG_AW'(CAP_BASE >> 2);
    localparam logic [CFG_AW-1:0] DAT_IDX = HDR_IDX + 1'b1;

    logic open_q;
    logic hit_hdr, hit_dat;

    always_comb begin
        open_q  = ~autoload_busy;
        hit_hdr = (cfg_addr == HDR_IDX);
        hit_dat = (cfg_addr == DAT_IDX);
        hdr_wr  = open_q & cfg_wr & hit_hdr;
        dat_wr  = open_q & cfg_wr & hit_dat;
        hdr_rd  = open_q & cfg_rd & hit_hdr;
        dat_rd  = open_q & cfg_rd & hit_dat;
    end
endmodule

// File: rtl/vpd_req_engine.sv
module vpd_req_engine import vpd_pkg::*; #(
    parameter int EAW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_we,
    input  logic [EAW-1:0]    start_addr,
    input  logic [DATA_W-1:0] start_wdata,
    input  logic              ee_ack,
    output logic              ee_req,
    output logic              ee_we,
    output logic [EAW-1:0]    ee_addr,
    output logic [DATA_W-1:0] ee_wdata,
    output logic              done
);
    typedef struct packed {
        logic              active;
        logic              we;
        logic [EAW-1:0]    addr;
        logic [DATA_W-1:0] wdata;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d = eng_q;
        if (eng_q.active) begin
            if (ee_ack) eng_d.active = 1'b0;
        end else if (start) begin
            eng_d.active = 1'b1;
            eng_d.we     = start_we;
            eng_d.addr   = start_addr;
            eng_d.wdata  = start_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign ee_req   = eng_q.active;
    assign ee_we    = eng_q.we;
    assign ee_addr  = eng_q.addr;
    assign ee_wdata = eng_q.wdata;
    assign done     = eng_q.active & ee_ack;
endmodule

// File: rtl/vpd_cap.sv
module vpd_cap import vpd_pkg::*; #(
    parameter int         VPD_BYTES = 224,
    parameter int         CFG_AW    = 6,
    parameter logic [7:0] CAP_BASE  = 8'hA0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         autoload_busy,
    input  logic                         cfg_wr,
    input  logic                         cfg_rd,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [3:0]                   cfg_be,
    input  logic [DATA_W-1:0]            cfg_wdata,
    output logic [DATA_W-1:0]            cfg_rdata,
    output logic                         ee_req,
    output logic                         ee_we,
    output logic [2:0]                   ee_dev,
    output logic [$clog2(VPD_BYTES)-1:0] ee_addr,
    output logic [DATA_W-1:0]            ee_wdata,
    input  logic                         ee_ack,
    input  logic [DATA_W-1:0]            ee_rdata
);
    localparam int EAW   = $clog2(VPD_BYTES);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic               flag;
        logic [ADDR_FW-1:0] addr;
        logic [DATA_W-1:0]  data;
        logic [DATA_W-1:0]  rdata;
    } cap_t;

    cap_t cap_d, cap_q;

    logic hdr_wr, dat_wr, hdr_rd, dat_rd;
    logic busy, done, launch, in_range;
    logic [ADDR_FW-1:0] cand_addr;
    logic flag_q;

    vpd_cfg_decode #(.CFG_AW(CFG_AW), .CAP_BASE(CAP_BASE)) dec_i (
        .cfg_wr        (cfg_wr),
        .cfg_rd        (cfg_rd),
        .cfg_addr      (cfg_addr),
        .autoload_busy (autoload_busy),
        .hdr_wr        (hdr_wr),
        .dat_wr        (dat_wr),
        .hdr_rd        (hdr_rd),
        .dat_rd        (dat_rd)
    );

    // Candidate address: lane 3 carries bits 14:8, lane 2 optionally bits 7:0
    always_comb begin
        cand_addr = {cfg_wdata[30:24], cfg_be[2] ? cfg_wdata[23:16] : cap_q.addr[7:0]};
        in_range  = (32'(cand_addr) < VPD_BYTES);
        launch    = hdr_wr & cfg_be[3] & ~busy & in_range;
    end

    vpd_req_engine #(.EAW(EAW)) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (launch),
        .start_we    (cfg_wdata[31]),
        .start_addr  (cand_addr[EAW-1:0]),
        .start_wdata (cap_q.data),
        .ee_ack      (ee_ack),
        .ee_req      (ee_req),
        .ee_we       (ee_we),
        .ee_addr     (ee_addr),
        .ee_wdata    (ee_wdata),
        .done        (done)
    );

    assign busy = ee_req;

    always_comb begin
        cap_d       = cap_q;
        cap_d.rdata = '0;
        if (launch) begin
            cap_d.addr = cand_addr;
            cap_d.flag = cfg_wdata[31];
        end
        if (dat_wr && !busy) begin
            for (int b = 0; b < LANES; b++) begin
                if (cfg_be[b]) cap_d.data[8*b +: 8] = cfg_wdata[8*b +: 8];
            end
        end
        if (done) begin
            if (ee_we) begin
                cap_d.flag = 1'b0;
            end else begin
                cap_d.flag = 1'b1;
                cap_d.data = ee_rdata;
            end
        end
        if (hdr_rd)      cap_d.rdata = {cap_q.flag, cap_q.addr, CAP_NEXT_END, CAP_ID_VPD};
        else if (dat_rd) cap_d.rdata = cap_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cfg_rdata = cap_q.rdata;
    assign ee_dev    = EE_DEV_ADDR;
    assign flag_q    = cap_q.flag;
endmodule

// File: rtl/vpd_cap_chk.sv
module vpd_cap_chk #(
    parameter int VPD_BYTES = 224,
    parameter int EAW       = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           autoload_busy,
    input logic           cfg_rd,
    input logic [31:0]    cfg_rdata,
    input logic           ee_req,
    input logic           ee_we,
    input logic [EAW-1:0] ee_addr,
    input logic [31:0]    ee_wdata,
    input logic           ee_ack,
    input logic           flag
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && !ee_ack |=> ee_req);
    // R8
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && !ee_ack |=> $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata));
    // R8
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && ee_ack |=> !ee_req);
    // R5
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req |-> (32'(ee_addr) < VPD_BYTES));
    // R3
    rd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && ee_ack && !ee_we |=> flag);
    // R4
    wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ee_req && ee_ack && ee_we |=> !flag);
    // R4
    wr_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_req) && ee_we |-> flag);
    // R7
    lock_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        autoload_busy && cfg_rd |=> cfg_rdata == 32'h0);
endmodule

bind vpd_cap vpd_cap_chk #(.VPD_BYTES(VPD_BYTES), .EAW($clog2(VPD_BYTES))) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .autoload_busy (autoload_busy),
    .cfg_rd        (cfg_rd),
    .cfg_rdata     (cfg_rdata),
    .ee_req        (ee_req),
    .ee_we         (ee_we),
    .ee_addr       (ee_addr),
    .ee_wdata      (ee_wdata),
    .ee_ack        (ee_ack),
    .flag          (flag_q)
);

// File: tb/vpd_cap_tb_top.sv
module vpd_cap_tb_top;
    localparam int         HDR = 40;
    localparam int         DAT = 41;
    localparam logic [7:0] BYTES = 8'd224;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        autoload_busy = 0;
    logic        cfg_wr = 0, cfg_rd = 0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        ee_req, ee_we;
    logic [2:0]  ee_dev;
    logic [7:0]  ee_addr;
    logic [31:0] ee_wdata;
    logic        ee_ack = 0;
    logic [31:0] ee_rdata = '0;

    int n_chk = 0, n_bad = 0;
    int ack_dly = 0;
    logic [31:0] mem [56];

    always #5 clk = ~clk;

    vpd_cap dut_i (
        .clk(clk), .rst_n(rst_n), .autoload_busy(autoload_busy),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ee_req(ee_req), .ee_we(ee_we), .ee_dev(ee_dev), .ee_addr(ee_addr),
        .ee_wdata(ee_wdata), .ee_ack(ee_ack), .ee_rdata(ee_rdata)
    );

    function automatic logic [31:0] init_word(int i);
        return {8'(i), 8'(~i), 8'(i * 3), 8'h5A};
    endfunction

    function automatic logic [31:0] hdr_val(logic flag, logic [14:0] a);
        return {flag, a, 8'h00, 8'h03};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural EEPROM controller
    initial begin
        int cnt = 0;
        for (int i = 0; i < 56; i++) mem[i] = init_word(i);
        forever begin
            @(negedge clk);
            if (ee_ack) begin
                ee_ack = 0;
                cnt = 0;
            end else if (ee_req) begin
                if (cnt >= ack_dly) begin
                    ee_ack = 1;
                    ee_rdata = mem[ee_addr >> 2];
                    if (ee_we) mem[ee_addr >> 2] = ee_wdata;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic cfg_write(int idx, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        cfg_wr = 1; cfg_addr = 6'(idx); cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic cfg_read(int idx, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1; cfg_addr = 6'(idx);
        @(negedge clk);
        cfg_rd = 0;
        d = cfg_rdata;
    endtask

    task automatic wait_idle();
        while (ee_req) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r, hv, dv;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 / R9 reset state
        check("R1 ee_req", 32'(ee_req), 0);
        check("R9 ee_dev", 32'(ee_dev), 0);
        cfg_read(HDR, r); check("R1 R2 header", r, hdr_val(0, 0));
        cfg_read(DAT, r); check("R1 data", r, 0);
        // R2 other offsets
        cfg_read(42, r); check("R2 index 42", r, 0);
        cfg_read(39, r); check("R2 index 39", r, 0);

        // R3 read sweep over every dword
        for (int i = 0; i < 56; i++) begin
            ack_dly = i % 4;
            cfg_write(HDR, {1'b0, 15'(i * 4), 16'h0}, 4'b1100);
            check("R3 req", 32'(ee_req), 1);
            check("R3 we", 32'(ee_we), 0);
            check("R3 addr", 32'(ee_addr), 32'(i * 4));
            wait_idle();
            cfg_read(HDR, r); check("R3 header", r, hdr_val(1, 15'(i * 4)));
            cfg_read(DAT, r); check("R3 data", r, init_word(i));
        end
        // R3 flag low while pending
        ack_dly = 6;
        cfg_write(HDR, {1'b0, 15'd8, 16'h0}, 4'b1100);
        cfg_read(HDR, r); check("R3 pending flag", r, hdr_val(0, 8));
        wait_idle();

        // R4 write sweep
        for (int i = 0; i < 56; i += 5) begin
            ack_dly = i % 3;
            dv = 32'hA5000000 | 32'(i);
            cfg_write(DAT, dv, 4'hF);
            cfg_write(HDR, {1'b1, 15'(i * 4), 16'h0}, 4'b1100);
            check("R4 we", 32'(ee_we), 1);
            check("R4 wdata", ee_wdata, dv);
            cfg_read(HDR, r);
            if (ack_dly >= 2) check("R4 pending flag", r, hdr_val(1, 15'(i * 4)));
            wait_idle();
            cfg_read(HDR, r); check("R4 header", r, hdr_val(0, 15'(i * 4)));
            cfg_read(DAT, r); check("R4 data kept", r, dv);
            check("R4 eeprom", mem[i], dv);
        end

        // R10 byte lanes and lane 3 disabled
        cfg_write(DAT, 32'hFFFFFFFF, 4'hF);
        cfg_write(DAT, 32'h11223344, 4'b0101);
        cfg_read(DAT, r); check("R10 lanes", r, 32'hFF22FF44);
        ack_dly = 0;
        cfg_write(HDR, {1'b0, 15'd4, 16'h0}, 4'b1100);
        wait_idle();
        hv = hdr_val(1, 4);
        cfg_write(HDR, {1'b0, 15'd12, 16'h0}, 4'b0111);
        check("R10 no lane3 req", 32'(ee_req), 0);
        cfg_read(HDR, r); check("R10 no lane3 header", r, hv);

        // R5 range boundary sweep
        for (int a = 216; a < 232; a++) begin
            cfg_write(HDR, {1'b0, 15'(a), 16'h0}, 4'b1100);
            if (a < 224) begin
                check("R5 in range req", 32'(ee_req), 1);
                wait_idle();
                hv = hdr_val(1, 15'(a));
            end else begin
                check("R5 reject req", 32'(ee_req), 0);
            end
            cfg_read(HDR, r); check("R5 header", r, hv);
        end
        cfg_write(HDR, {1'b1, 15'h7FFF, 16'h0}, 4'b1100);
        check("R5 max reject", 32'(ee_req), 0);
        cfg_read(HDR, r); check("R5 max header", r, hv);
        check("R5 bound", 32'(BYTES), 224);

        // R6 / R8 writes while pending
        ack_dly = 8;
        cfg_write(HDR, {1'b0, 15'd12, 16'h0}, 4'b1100);
        cfg_write(DAT, 32'hDEADBEEF, 4'hF);
        cfg_write(HDR, {1'b0, 15'd20, 16'h0}, 4'b1100);
        check("R6 R8 addr held", 32'(ee_addr), 12);
        check("R8 req held", 32'(ee_req), 1);
        wait_idle();
        check("R8 req dropped", 32'(ee_req), 0);
        cfg_read(HDR, r); check("R6 header", r, hdr_val(1, 12));
        cfg_read(DAT, r); check("R6 data", r, mem[3]);

        // R6 header write in the acknowledge cycle
        ack_dly = 3;
        cfg_write(HDR, {1'b0, 15'd16, 16'h0}, 4'b1100);
        @(posedge ee_ack);
        cfg_wr = 1; cfg_addr = 6'(HDR); cfg_wdata = {1'b0, 15'd24, 16'h0}; cfg_be = 4'b1100;
        @(negedge clk); cfg_wr = 0;
        repeat (3) @(negedge clk);
        check("R6 ack collide req", 32'(ee_req), 0);
        cfg_read(HDR, r); check("R6 ack collide header", r, hdr_val(1, 16));
        // R6 data write in the acknowledge cycle
        cfg_write(HDR, {1'b0, 15'd28, 16'h0}, 4'b1100);
        @(posedge ee_ack);
        cfg_wr = 1; cfg_addr = 6'(DAT); cfg_wdata = 32'h12345678; cfg_be = 4'hF;
        @(negedge clk); cfg_wr = 0;
        wait_idle();
        cfg_read(DAT, r); check("R6 ack collide data", r, mem[7]);

        // R7 autoload lockout
        cfg_read(HDR, hv);
        cfg_read(DAT, dv);
        autoload_busy = 1;
        cfg_read(HDR, r); check("R7 header zero", r, 0);
        cfg_read(DAT, r); check("R7 data zero", r, 0);
        cfg_write(HDR, {1'b0, 15'd32, 16'h0}, 4'b1100);
        check("R7 no req", 32'(ee_req), 0);
        cfg_write(DAT, 32'h0BADF00D, 4'hF);
        autoload_busy = 0;
        cfg_read(HDR, r); check("R7 header kept", r, hv);
        cfg_read(DAT, r); check("R7 data kept", r, dv);
        check("R9 ee_dev end", 32'(ee_dev), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule